// File: doc/BRIEF.md
# Switch-Order k-Select Detector

This block observes a vector of one-bit neuron outputs during a ramp perturbation. Each output toggles once at a time that reflects its neuron's distance to a stored pattern. The block finds the neurons that toggle early or late. In first-k mode it returns the k neurons that toggled earliest, which is a k-loser-take-all selection. In last-k mode it returns the k neurons that had not yet toggled when all the others had, which is a k-winner-take-all selection.

The outputs pass through a two-flop synchronizer. A start strobe records the level of every output as its baseline. From then on, a sticky per-neuron flag marks every output that has departed from its baseline. A population count of these flags is compared against a threshold chosen from k and the mode. When the count reaches the threshold, a bank of registers freezes the selection mask and raises a valid flag. The result stays frozen until the next start strobe. When several neurons toggle in the same cycle and push the count past the threshold, the whole group is treated as tied and is kept in the selection.

Top module: `switch_rank_sel`

## Requirements
- R1: While reset is high and on the cycle after it, `sel_mask` is all zeros, and `sel_valid` and `sel_tie` are 0.
- R2: With `sel_last` = 0 (first-k mode), `sel_valid` rises once at least k neurons have switched. `sel_mask` then has a 1 at bit i for each neuron i that has switched.
- R3: With `sel_last` = 1 (last-k mode), `sel_valid` rises once at least N−k neurons have switched. `sel_mask` then has a 1 for each neuron that has not switched.
- R4: A neuron counts as switched once its synchronized level differs from the level sampled at the start strobe, in either direction. It stays counted even if it later returns to that level.
- R5: If the neurons switching in one cycle take the count past the threshold, `sel_tie` is 1. In first-k mode the mask then holds every switched neuron. In last-k mode it holds every neuron that had not switched before that cycle. If the count lands exactly on the threshold, `sel_tie` is 0.
- R6: A start with k = 0 gives `sel_valid` = 1 and an all-zero mask on the cycle after the strobe. A start in last-k mode with k ≥ N gives `sel_valid` = 1 and an all-ones mask on that same cycle. Any k above N is treated as N.
- R7: Once `sel_valid` is 1, it stays 1, and `sel_mask` and `sel_tie` keep their values, until the next start strobe. Later neuron toggles do not change them.
- R8: A start strobe that is not an immediate case clears `sel_valid`, `sel_mask` and `sel_tie` on the next cycle and begins a new detection.
- R9: A neuron toggle that completes the threshold shows on `sel_valid` at the third rising edge after the input changes, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle strobe: sample baselines and begin detection |
| sel_last | input | 1 | 0 = first-k (loser) selection, 1 = last-k (winner) selection |
| k_i | input | CW | Number of neurons to select, sampled at the strobe |
| neur_i | input | N | Asynchronous neuron outputs |
| sel_mask | output | N | Registered selection mask |
| sel_valid | output | 1 | Result frozen and valid |
| sel_tie | output | 1 | Threshold was overshot by a simultaneous group |

## Verification
A wrong baseline or a lost sticky flag shows up at the ports as a mask with a missing or extra bit. It can also show up as a valid flag that rises one or more toggle steps early or late. The directed steps are spaced four cycles apart, so the first wrong step exposes the fault. A wrong threshold or mode decode shows as a wrong mask population when valid rises. A fault in synchronizer depth shifts the rising edge of valid by a cycle against the exact edge the bench expects. A fault in the freeze logic shows as a mask that changes after a later toggle while valid is still high.

// File: rtl/srs_pkg.sv
package srs_pkg;
  typedef enum logic {SEL_FIRST = 1'b0, SEL_LAST = 1'b1} sel_mode_e;
endpackage

// File: rtl/srs_sync.sv
module srs_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        meta_q[g] <= 1'b0;
        stab_q[g] <= 1'b0;
      end else begin
        meta_q[g] <= d_i[g];
        stab_q[g] <= meta_q[g];
      end
    end
  end

  assign q_o = stab_q;
endmodule

// File: rtl/srs_popcnt.sv
module srs_popcnt #(
  parameter int W  = 8,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  bits_i,
  output logic [CW-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < W; i++) cnt_o = cnt_o + CW'(bits_i[i]);
  end
endmodule

// File: rtl/srs_core.sv
module srs_core
  import srs_pkg::*;
#(
  parameter int N  = 8,
  parameter int CW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          sel_last,
  input  logic [CW-1:0] k_i,
  input  logic [N-1:0]  samp_i,
  input  logic [CW-1:0] cnt_i,
  output logic [N-1:0]  flag_nxt_o,
  output logic [N-1:0]  mask_o,
  output logic          valid_o,
  output logic          tie_o
);
  localparam logic [CW-1:0] NCNT = CW'(N);

  logic [N-1:0]  base_q;
  logic [N-1:0]  flag_q;
  logic [CW-1:0] thr_q;
  sel_mode_e     mode_q;
  logic          armed_q;

  logic [CW-1:0] k_eff;
  logic          hit;
  logic          over;
  logic [N-1:0]  pick;

  assign k_eff      = (k_i > NCNT) ? NCNT : k_i;
  assign flag_nxt_o = flag_q | (samp_i ^ base_q);
  assign hit        = (cnt_i >= thr_q);
  assign over       = (cnt_i > thr_q);

  always_comb begin
    if (mode_q == SEL_FIRST) pick = flag_nxt_o;
    else if (over)           pick = ~flag_q;
    else                     pick = ~flag_nxt_o;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      flag_q  <= '0;
      thr_q   <= '0;
      mode_q  <= SEL_FIRST;
      armed_q <= 1'b0;
      mask_o  <= '0;
      valid_o <= 1'b0;
      tie_o   <= 1'b0;
    end else if (start_i) begin
      base_q <= samp_i;
      flag_q <= '0;
      mode_q <= sel_mode_e'(sel_last);
      thr_q  <= sel_last ? (NCNT - k_eff) : k_eff;
      tie_o  <= 1'b0;
      if (k_eff == '0) begin
        armed_q <= 1'b0;
        valid_o <= 1'b1;
        mask_o  <= '0;
      end else if (sel_last && (k_eff == NCNT)) begin
        armed_q <= 1'b0;
        valid_o <= 1'b1;
        mask_o  <= '1;
      end else begin
        armed_q <= 1'b1;
        valid_o <= 1'b0;
        mask_o  <= '0;
      end
    end else if (armed_q) begin
      flag_q <= flag_nxt_o;
      if (hit) begin
        armed_q <= 1'b0;
        valid_o <= 1'b1;
        mask_o  <= pick;
        tie_o   <= over;
      end
    end
  end
endmodule

// File: rtl/switch_rank_sel.sv
module switch_rank_sel #(
  parameter int N  = 8,
  parameter int CW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          sel_last,
  input  logic [CW-1:0] k_i,
  input  logic [N-1:0]  neur_i,
  output logic [N-1:0]  sel_mask,
  output logic          sel_valid,
  output logic          sel_tie
);
  logic [N-1:0]  samp;
  logic [N-1:0]  flag_nxt;
  logic [CW-1:0] cnt;

  srs_sync #(.W(N)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (neur_i),
    .q_o (samp)
  );

  srs_popcnt #(.W(N), .CW(CW)) u_cnt (
    .bits_i (flag_nxt),
    .cnt_o  (cnt)
  );

  srs_core #(.N(N), .CW(CW)) u_core (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .sel_last   (sel_last),
    .k_i        (k_i),
    .samp_i     (samp),
    .cnt_i      (cnt),
    .flag_nxt_o (flag_nxt),
    .mask_o     (sel_mask),
    .valid_o    (sel_valid),
    .tie_o      (sel_tie)
  );
endmodule

// File: rtl/srs_chk.sv
module srs_chk #(
  parameter int N  = 8,
  parameter int CW = $clog2(N + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          start_i,
  input logic          sel_last,
  input logic [CW-1:0] k_i,
  input logic [N-1:0]  sel_mask,
  input logic          sel_valid,
  input logic          sel_tie
);
  localparam logic [CW-1:0] NCNT = CW'(N);
  logic [CW-1:0] kq;
  logic          lastq;

  always_ff @(posedge clk) begin
    if (rst) begin
      kq    <= '0;
      lastq <= 1'b0;
    end else if (start_i) begin
      kq    <= (k_i > NCNT) ? NCNT : k_i;
      lastq <= sel_last;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!sel_valid && !sel_tie && sel_mask == '0));

  // R7
  valid_hold_chk: assert property (@(posedge clk) disable iff (rst)
    sel_valid && !start_i |=> sel_valid);

  // R7
  result_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    sel_valid && !start_i |=> $stable(sel_mask) && $stable(sel_tie));

  // R6
  kzero_chk: assert property (@(posedge clk) disable iff (rst)
    start_i && k_i == '0 |=> sel_valid && sel_mask == '0 && !sel_tie);

  // R8
  start_clear_chk: assert property (@(posedge clk) disable iff (rst)
    start_i && k_i != '0 && !(sel_last && k_i >= NCNT) |=> !sel_valid && !sel_tie);

  // R5
  tie_valid_chk: assert property (@(posedge clk) disable iff (rst)
    sel_tie |-> sel_valid);

  // R2
  first_count_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sel_valid) && !lastq && !sel_tie |-> $countones(sel_mask) == int'(kq));

  // R3
  last_count_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sel_valid) && lastq && !sel_tie |-> $countones(sel_mask) == int'(kq));

  // R5
  tie_first_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sel_tie) && !lastq |-> $countones(sel_mask) > int'(kq));
endmodule

bind switch_rank_sel srs_chk #(.N(N), .CW(CW)) u_srs_chk (
  .clk       (clk),
  .rst       (rst),
  .start_i   (start_i),
  .sel_last  (sel_last),
  .k_i       (k_i),
  .sel_mask  (sel_mask),
  .sel_valid (sel_valid),
  .sel_tie   (sel_tie)
);

// File: tb/test_switch_rank_sel.sv
module test_switch_rank_sel;
  localparam int N  = 8;
  localparam int CW = $clog2(N + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0;
  logic          sel_last = 1'b0;
  logic [CW-1:0] k_i = '0;
  logic [N-1:0]  neur_i = '0;
  logic [N-1:0]  sel_mask;
  logic          sel_valid;
  logic          sel_tie;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  switch_rank_sel #(.N(N), .CW(CW)) i_switch_rank_sel (
    .clk(clk), .rst(rst), .start_i(start_i), .sel_last(sel_last),
    .k_i(k_i), .neur_i(neur_i), .sel_mask(sel_mask),
    .sel_valid(sel_valid), .sel_tie(sel_tie)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic begin_run(input logic [N-1:0] lvl, input logic last, input int k);
    neur_i = lvl;
    cyc(3);
    start_i  = 1'b1;
    sel_last = last;
    k_i      = CW'(k);
    cyc(1);
    start_i  = 1'b0;
  endtask

  task automatic flip(input logic [N-1:0] bits);
    neur_i = neur_i ^ bits;
    cyc(4);
  endtask

  task automatic t_reset();
    check("R1 mask", 32'(sel_mask), 0);
    check("R1 valid", 32'(sel_valid), 0);
    check("R1 tie", 32'(sel_tie), 0);
  endtask

  task automatic t_first_k();
    begin_run(8'h00, 1'b0, 3);
    check("R8 cleared", 32'(sel_valid), 0);
    flip(8'h04);
    flip(8'h20);
    check("R2 not early", 32'(sel_valid), 0);
    neur_i = neur_i ^ 8'h01;
    cyc(2);
    check("R9 no valid at 2nd edge", 32'(sel_valid), 0);
    cyc(1);
    check("R9 valid at 3rd edge", 32'(sel_valid), 1);
    check("R2 mask", 32'(sel_mask), 32'h25);
    check("R5 exact no tie", 32'(sel_tie), 0);
    flip(8'h80);
    check("R7 mask held", 32'(sel_mask), 32'h25);
    check("R7 valid held", 32'(sel_valid), 1);
  endtask

  task automatic t_last_k();
    begin_run(8'hFF, 1'b1, 2);
    flip(8'h01);
    flip(8'h01);
    for (int b = 1; b < 5; b++) flip(8'(1 << b));
    check("R4 sticky not early", 32'(sel_valid), 0);
    flip(8'h20);
    check("R3 valid", 32'(sel_valid), 1);
    check("R3 R4 mask", 32'(sel_mask), 32'hC0);
    check("R5 exact no tie", 32'(sel_tie), 0);
  endtask

  task automatic t_tie_first();
    begin_run(8'h00, 1'b0, 2);
    flip(8'h02);
    flip(8'h58);
    check("R5 first valid", 32'(sel_valid), 1);
    check("R5 first mask", 32'(sel_mask), 32'h5A);
    check("R5 first tie", 32'(sel_tie), 1);
  endtask

  task automatic t_tie_last();
    begin_run(8'h00, 1'b1, 3);
    flip(8'h07);
    check("R3 not early", 32'(sel_valid), 0);
    flip(8'h38);
    check("R5 last mask", 32'(sel_mask), 32'hF8);
    check("R5 last tie", 32'(sel_tie), 1);
  endtask

  task automatic t_immediate();
    begin_run(8'h00, 1'b0, 0);
    check("R6 k0 valid", 32'(sel_valid), 1);
    check("R6 k0 mask", 32'(sel_mask), 0);
    flip(8'h0F);
    check("R7 k0 held", 32'(sel_mask), 0);
    begin_run(8'h00, 1'b1, 0);
    check("R6 k0 last valid", 32'(sel_valid), 1);
    check("R6 k0 last mask", 32'(sel_mask), 0);
    begin_run(8'h00, 1'b1, 15);
    check("R6 kN last valid", 32'(sel_valid), 1);
    check("R6 kN last mask", 32'(sel_mask), 32'hFF);
    begin_run(8'h00, 1'b0, 12);
    flip(8'h7F);
    check("R6 clamp not early", 32'(sel_valid), 0);
    flip(8'h80);
    check("R6 clamp mask", 32'(sel_mask), 32'hFF);
    check("R6 clamp tie", 32'(sel_tie), 0);
  endtask

  task automatic t_restart();
    begin_run(8'hF0, 1'b0, 1);
    check("R8 valid cleared", 32'(sel_valid), 0);
    check("R8 mask cleared", 32'(sel_mask), 0);
    check("R8 tie cleared", 32'(sel_tie), 0);
    flip(8'h10);
    check("R4 falling mask", 32'(sel_mask), 32'h10);
  endtask

  initial begin
    cyc(3);
    rst = 1'b0;
    cyc(1);
    t_reset();
    t_first_k();
    t_last_k();
    t_tie_first();
    t_tie_last();
    t_immediate();
    t_restart();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule